// File: doc/BRIEF.md
# Interlaced Field-Weave Capture Address Generator

This block sits between a digital video decoder and a single-port frame SRAM. It runs on the decoder's capture clock, which is twice the pixel rate, so one luma sample arrives every second clock. The block watches the line-valid and field-valid levels and the field parity bit. For each sample it decides whether the sample falls inside the active window. For each sample that does, it issues one write strobe with an address and a data word.

A programmable number of blanking lines is skipped after every field start, and a programmable number of blanking samples is skipped after every line start. Only then do the row and column counters advance. Each row is padded to a power-of-two pitch. The inverted field parity is placed as the bit just above the column, so the odd field and the even field interleave line by line into one progressive frame.

A one-cycle frame-complete pulse goes out when a field finishes and a field of the other parity has also finished since the last pulse. A downstream buffer swap can use this pulse. A field that is cut short by a new field start does not count toward it.

Top module: `fieldweave_capture`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wrEn` and `frameDone` are 0 and `wrAddr` is 0.
- R2: Before the first rising edge of `vSync` after reset, no write is issued, whatever `hSync` does.
- R3: After a rising edge of `vSync`, the first `lineSkip` rising edges of `hSync` are skipped. The following lines are captured as rows 0, 1, 2, and so on.
- R4: Samples are taken on the clock in which `hSync` is first seen high and on every second clock after that, while `hSync` stays high. On a captured line, samples 0 to `pixSkip`-1 are dropped. The next ACT_PIX samples are written to columns 0 to ACT_PIX-1. Any later samples on that line are ignored.
- R5: `wrEn` is high for exactly one clock per written sample. It goes high in the clock after the edge that sampled `pixData`. `wrAddr` and `wrData` keep their values until the next write.
- R6: The write address is `{row[ROW_BITS-1:0], ~parity, column[COL_BITS-1:0]}`. Here parity is the `fieldId` value latched at the rising edge of `vSync` (1 marks an odd field). Each row therefore owns 2^COL_BITS locations.
- R7: The row counter advances only after a line has written all ACT_PIX columns. If `hSync` falls earlier, the next line is written again to the same row.
- R8: Once ACT_LINES rows are complete, further lines in that field are ignored.
- R9: `frameDone` is a one-clock pulse. It is high in the same clock as the final write of a completed field, when a completed field of the other parity has been seen since the previous pulse (or since reset). The pulse clears both records.
- R10: A rising edge of `vSync` always restarts row and skip counting. A field that was interrupted before completing does not count toward R9.
- R11: A change of `fieldId` after the rising edge of `vSync` has no effect on the addresses of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| hSync | input | 1 | Line-valid level from the decoder |
| vSync | input | 1 | Field-valid level from the decoder |
| fieldId | input | 1 | Field parity, 1 for an odd field |
| pixData | input | DATA_W | Luma sample |
| lineSkip | input | LSKIP_W | Blanking lines to skip per field |
| pixSkip | input | PSKIP_W | Blanking samples to skip per line |
| wrEn | output | 1 | SRAM write strobe |
| wrAddr | output | ROW_BITS+1+COL_BITS | SRAM write address |
| wrData | output | DATA_W | SRAM write data |
| frameDone | output | 1 | Both parities of a frame are stored |

## Verification
The assertions assume four things about the decoder side:
- a rising edge of `hSync` never falls in the same clock as a rising edge of `vSync`;
- `hSync` is low for at least one clock between lines;
- `pixData` is held for the two clocks of each sample;
- `fieldId` is settled when `vSync` rises.

The single-cycle strobe and the hold-between-writes property both depend on these assumptions. The stimulus respects them: it raises `vSync` several clocks before the first line, leaves four idle clocks after each line, and changes data only on sample boundaries. The stimulus also flips parity only after the field has started.

// File: rtl/fw_pkg.sv
package fw_pkg;

  // Strobes passed from the sequencing control to the address datapath.
  typedef struct packed {
    logic fieldStart;  // new field: clear rows, latch parity
    logic lineStart;   // captured line begins: column restarts at zero
    logic pixWrite;    // current sample is written
    logic lineEnd;     // current write fills the last column
  } ctrlStrobes_t;

endpackage

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
#(
  parameter int ACT_PIX = 720,
  parameter int PSKIP_W = 8,
  parameter int LSKIP_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hSync,
  input  logic               vSync,
  input  logic [LSKIP_W-1:0] lineSkip,
  input  logic [PSKIP_W-1:0] pixSkip,
  input  logic               rowsFull,
  input  logic               colIsLast,
  output ctrlStrobes_t       strobes
);

  logic               hsDly, vsDly, phase, lineOn, fieldOn;
  logic [LSKIP_W-1:0] lineSkipCnt;
  logic [PSKIP_W-1:0] pixSkipCnt;

  logic               hsRise, vsRise, sampleNow, lineGo, lineLive;
  logic               inSkip, pixWrite, atLast;
  logic [PSKIP_W-1:0] skipIdx;

  assign hsRise    = hSync & ~hsDly;
  assign vsRise    = vSync & ~vsDly;
  // First sample on the edge that sees the line rise, then every other clock.
  assign sampleNow = hSync & (hsRise | ~phase);
  assign lineGo    = hsRise & ~vsRise & fieldOn & (lineSkipCnt >= lineSkip) & ~rowsFull;
  assign lineLive  = ~vsRise & (lineGo | (lineOn & hSync & ~hsRise));
  assign skipIdx   = hsRise ? '0 : pixSkipCnt;
  assign inSkip    = skipIdx < pixSkip;
  assign pixWrite  = sampleNow & lineLive & ~inSkip;

  // The column register is stale in the clock a line starts, so the
  // last-column test there depends only on the line width.
  generate
    if (ACT_PIX == 1) begin : gOnePix
      assign atLast = 1'b1;
    end else begin : gMultiPix
      assign atLast = ~lineGo & colIsLast;
    end
  endgenerate

  always_comb begin
    strobes.fieldStart = vsRise;
    strobes.lineStart  = lineGo;
    strobes.pixWrite   = pixWrite;
    strobes.lineEnd    = pixWrite & atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsDly       <= 1'b0;
      vsDly       <= 1'b0;
      phase       <= 1'b0;
      lineOn      <= 1'b0;
      fieldOn     <= 1'b0;
      lineSkipCnt <= '0;
      pixSkipCnt  <= '0;
    end else begin
      hsDly <= hSync;
      vsDly <= vSync;
      phase <= hsRise ? 1'b1 : ~phase;

      if (vsRise) begin
        fieldOn     <= 1'b1;
        lineSkipCnt <= '0;
      end else if (hsRise && fieldOn && (lineSkipCnt < lineSkip)) begin
        lineSkipCnt <= lineSkipCnt + 1'b1;
      end

      if (vsRise)                  lineOn <= 1'b0;
      else if (strobes.lineEnd)    lineOn <= 1'b0;
      else if (lineGo)             lineOn <= 1'b1;
      else if (!hSync)             lineOn <= 1'b0;

      if (sampleNow && lineLive)
        pixSkipCnt <= inSkip ? skipIdx + 1'b1 : skipIdx;
    end
  end

endmodule

// File: rtl/fw_datapath.sv
module fw_datapath
  import fw_pkg::*;
#(
  parameter int ACT_PIX   = 720,
  parameter int ACT_LINES = 243,
  parameter int COL_BITS  = 10,
  parameter int ROW_BITS  = 8,
  parameter int DATA_W    = 10,
  localparam int ADDR_W   = ROW_BITS + 1 + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              fieldId,
  input  logic [DATA_W-1:0] pixData,
  output logic              colIsLast,
  output logic              rowsFull,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              frameDone
);

  localparam logic [COL_BITS-1:0] LAST_COL = COL_BITS'(ACT_PIX - 1);
  localparam logic [ROW_BITS-1:0] ROW_LIM  = ROW_BITS'(ACT_LINES);
  localparam logic [ROW_BITS-1:0] LAST_ROW = ROW_BITS'(ACT_LINES - 1);

  logic [COL_BITS-1:0] colCnt, colNow;
  logic [ROW_BITS-1:0] rowCnt;
  logic                oddField, gotOdd, gotEven, fieldComplete, otherSeen;

  assign colNow        = strobes.lineStart ? '0 : colCnt;
  assign colIsLast     = (colCnt == LAST_COL);
  assign rowsFull      = (rowCnt == ROW_LIM);
  assign fieldComplete = strobes.lineEnd & (rowCnt == LAST_ROW);
  assign otherSeen     = oddField ? gotEven : gotOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt    <= '0;
      rowCnt    <= '0;
      oddField  <= 1'b0;
      gotOdd    <= 1'b0;
      gotEven   <= 1'b0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      frameDone <= 1'b0;
    end else begin
      if (strobes.pixWrite)       colCnt <= colNow + 1'b1;
      else if (strobes.lineStart) colCnt <= '0;

      if (strobes.fieldStart) begin
        rowCnt   <= '0;
        oddField <= fieldId;
      end else if (strobes.lineEnd) begin
        rowCnt <= rowCnt + 1'b1;
      end

      wrEn <= strobes.pixWrite;
      if (strobes.pixWrite) begin
        wrAddr <= {rowCnt, ~oddField, colNow};
        wrData <= pixData;
      end

      frameDone <= 1'b0;
      if (fieldComplete) begin
        if (otherSeen) begin
          frameDone <= 1'b1;
          gotOdd    <= 1'b0;
          gotEven   <= 1'b0;
        end else if (oddField) begin
          gotOdd <= 1'b1;
        end else begin
          gotEven <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fieldweave_capture.sv
module fieldweave_capture
  import fw_pkg::*;
#(
  parameter int ACT_PIX   = 720,
  parameter int ACT_LINES = 243,
  parameter int COL_BITS  = 10,
  parameter int ROW_BITS  = 8,
  parameter int DATA_W    = 10,
  parameter int PSKIP_W   = 8,
  parameter int LSKIP_W   = 6,
  localparam int ADDR_W   = ROW_BITS + 1 + COL_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hSync,
  input  logic               vSync,
  input  logic               fieldId,
  input  logic [DATA_W-1:0]  pixData,
  input  logic [LSKIP_W-1:0] lineSkip,
  input  logic [PSKIP_W-1:0] pixSkip,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               frameDone
);

  ctrlStrobes_t strobes;
  logic         colIsLast, rowsFull;

  fw_ctrl #(
    .ACT_PIX (ACT_PIX),
    .PSKIP_W (PSKIP_W),
    .LSKIP_W (LSKIP_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hSync     (hSync),
    .vSync     (vSync),
    .lineSkip  (lineSkip),
    .pixSkip   (pixSkip),
    .rowsFull  (rowsFull),
    .colIsLast (colIsLast),
    .strobes   (strobes)
  );

  fw_datapath #(
    .ACT_PIX   (ACT_PIX),
    .ACT_LINES (ACT_LINES),
    .COL_BITS  (COL_BITS),
    .ROW_BITS  (ROW_BITS),
    .DATA_W    (DATA_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fieldId   (fieldId),
    .pixData   (pixData),
    .colIsLast (colIsLast),
    .rowsFull  (rowsFull),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .frameDone (frameDone)
  );

endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int ACT_PIX   = 720,
  parameter int ACT_LINES = 243,
  parameter int COL_BITS  = 10,
  parameter int ROW_BITS  = 8,
  parameter int DATA_W    = 10,
  localparam int ADDR_W   = ROW_BITS + 1 + COL_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              frameDone
);

  localparam logic [COL_BITS-1:0] COL_LIM  = COL_BITS'(ACT_PIX);
  localparam logic [COL_BITS-1:0] LAST_COL = COL_BITS'(ACT_PIX - 1);
  localparam logic [ROW_BITS-1:0] ROW_LIM  = ROW_BITS'(ACT_LINES);
  localparam logic [ROW_BITS-1:0] LAST_ROW = ROW_BITS'(ACT_LINES - 1);

  logic [COL_BITS-1:0] colOf;
  logic [ROW_BITS-1:0] rowOf;
  assign colOf = wrAddr[COL_BITS-1:0];
  assign rowOf = wrAddr[ADDR_W-1 -: ROW_BITS];

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);                                                    // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (wrEn || ($stable(wrAddr) && $stable(wrData))));          // R5
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (colOf < COL_LIM));                                        // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (rowOf < ROW_LIM));                                        // R8
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (wrEn && colOf == LAST_COL && rowOf == LAST_ROW));    // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);                                          // R9

endmodule

bind fieldweave_capture fw_checker #(
  .ACT_PIX   (ACT_PIX),
  .ACT_LINES (ACT_LINES),
  .COL_BITS  (COL_BITS),
  .ROW_BITS  (ROW_BITS),
  .DATA_W    (DATA_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .frameDone (frameDone)
);

// File: tb/sim_fieldweave_capture.sv
`timescale 1ns/1ps
module sim_fieldweave_capture;

  localparam int ACT_PIX   = 6;
  localparam int ACT_LINES = 3;
  localparam int COL_BITS  = 10;
  localparam int ROW_BITS  = 8;
  localparam int DATA_W    = 10;
  localparam int PSKIP_W   = 8;
  localparam int LSKIP_W   = 6;
  localparam int ADDR_W    = ROW_BITS + 1 + COL_BITS;
  localparam int LINE_LEN  = 12;
  localparam int NVEC      = 5;

  // Vector: {fid, flip, lineSkip[2:0], pixSkip[2:0], lines[3:0], truncLine[3:0], expWrites[7:0], expDone[1:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'd1, 3'd2, 4'd4, 4'd15, 8'd18, 2'd0},  // odd field: R3 R4
    {1'b0, 1'b1, 3'd1, 3'd2, 4'd5, 4'd15, 8'd18, 2'd1},  // even, extra line, fid flips: R8 R9 R11
    {1'b0, 1'b0, 3'd0, 3'd0, 4'd3, 4'd15, 8'd18, 2'd0},  // even, no skips: R3 R4
    {1'b1, 1'b0, 3'd2, 3'd3, 4'd4, 4'd15, 8'd12, 2'd0},  // odd cut short: R10
    {1'b1, 1'b0, 3'd2, 3'd3, 4'd6, 4'd3,  8'd20, 2'd1}   // odd, truncated line: R7 R9 R10
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               hSync = 1'b0, vSync = 1'b0, fieldId = 1'b0;
  logic [DATA_W-1:0]  pixData = '0;
  logic [LSKIP_W-1:0] lineSkip = '0;
  logic [PSKIP_W-1:0] pixSkip = '0;
  logic               wrEn, frameDone;
  logic [ADDR_W-1:0]  wrAddr;
  logic [DATA_W-1:0]  wrData;

  always #2.5 clk = ~clk;

  fieldweave_capture #(
    .ACT_PIX(ACT_PIX), .ACT_LINES(ACT_LINES), .COL_BITS(COL_BITS),
    .ROW_BITS(ROW_BITS), .DATA_W(DATA_W), .PSKIP_W(PSKIP_W), .LSKIP_W(LSKIP_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .hSync(hSync), .vSync(vSync), .fieldId(fieldId),
    .pixData(pixData), .lineSkip(lineSkip), .pixSkip(pixSkip),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .frameDone(frameDone)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  int wrCount = 0, doneCount = 0, r5Bad = 0, r9Bad = 0;
  bit finished = 1'b0, prevWr = 1'b0, seenWr = 1'b0, needFirst = 1'b0;
  logic [ADDR_W-1:0] lastAddr, firstAddr;
  logic [DATA_W-1:0] lastData;
  logic [DATA_W-1:0] mem [int];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int tag, input int line, input int smp);
    return {tag[2:0], line[2:0], smp[3:0]};
  endfunction

  // SRAM model and strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) begin
        mem[int'(wrAddr)] = wrData;
        wrCount++;
        if (prevWr) r5Bad++;
        if (needFirst) begin firstAddr = wrAddr; needFirst = 1'b0; end
        lastAddr = wrAddr;
        lastData = wrData;
        seenWr = 1'b1;
      end else if (seenWr && (wrAddr != lastAddr || wrData != lastData)) begin
        r5Bad++;
      end
      prevWr = wrEn;
      if (frameDone) begin
        doneCount++;
        if (!wrEn) r9Bad++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic driveLine(input int tag, input int line, input int nSmp);
    hSync = 1'b1;
    for (int k = 0; k < nSmp; k++) begin
      pixData = pat(tag, line, k);
      repeat (2) @(negedge clk);
    end
    hSync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic runField(input int tag, input bit fid, input bit flip, input int ls,
                          input int ps, input int nl, input int tr);
    lineSkip = LSKIP_W'(ls);
    pixSkip  = PSKIP_W'(ps);
    fieldId  = fid;
    vSync    = 1'b1;
    repeat (3) @(negedge clk);
    if (flip) fieldId = ~fid;
    for (int l = 0; l < nl; l++)
      driveLine(tag, l, (l == tr) ? ps + 2 : LINE_LEN);
    vSync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wrEn == 1'b0 && frameDone == 1'b0 && wrAddr == '0, "R1 reset state", int'(wrAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(wrEn == 1'b0 && frameDone == 1'b0, "R1 after release", int'(wrEn), 0);

    for (int v = 0; v < NVEC; v++) begin
      bit fid, flip;
      int ls, ps, nl, tr, ew, ed, w0, d0, rows, raw;
      logic [ADDR_W-1:0] a;
      {fid, flip} = VEC[v][25:24];
      ls = int'(VEC[v][23:21]);
      ps = int'(VEC[v][20:18]);
      nl = int'(VEC[v][17:14]);
      tr = int'(VEC[v][13:10]);
      ew = int'(VEC[v][9:2]);
      ed = int'(VEC[v][1:0]);
      mem.delete();
      w0 = wrCount;
      d0 = doneCount;
      needFirst = 1'b1;
      runField(v, fid, flip, ls, ps, nl, tr);
      check(wrCount - w0 == ew, "R3/R8 write count", wrCount - w0, ew);
      check(doneCount - d0 == ed, "R9 R10 frame done count", doneCount - d0, ed);
      check(firstAddr == {ROW_BITS'(0), ~fid, COL_BITS'(0)}, "R6 first address",
            int'(firstAddr), int'({ROW_BITS'(0), ~fid, COL_BITS'(0)}));
      rows = (nl - ls < ACT_LINES) ? nl - ls : ACT_LINES;
      for (int r = 0; r < rows; r++) begin
        for (int c = 0; c < ACT_PIX; c++) begin
          raw = ls + r;
          if (tr != 15 && raw >= tr) raw++;  // R7: truncated line rewritten by next
          a = {ROW_BITS'(r), ~fid, COL_BITS'(c)};
          check(mem.exists(int'(a)) && mem[int'(a)] == pat(v, raw, ps + c),
                "R4 R6 R7 R11 stored pixel",
                mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, int'(pat(v, raw, ps + c)));
        end
      end
    end

    // Directed: reset mid-stream, then lines with no field start.
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(wrEn == 1'b0 && frameDone == 1'b0 && wrAddr == '0, "R1 reset re-entry", int'(wrAddr), 0);
    rstN = 1'b1;
    seenWr = 1'b0;
    prevWr = 1'b0;
    begin
      int w0;
      w0 = wrCount;
      lineSkip = '0;
      pixSkip = '0;
      for (int l = 0; l < 3; l++) driveLine(7, l, LINE_LEN);
      check(wrCount == w0, "R2 no write before field start", wrCount - w0, 0);
    end

    check(r5Bad == 0, "R5 strobe width and hold", r5Bad, 0);
    check(r9Bad == 0, "R9 done aligned with write", r9Bad, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule